// File: doc/BRIEF.md
# Dimmer-Aware Boost Chopper Gate Sequencer

This block drives the gate of the boost chopper switch in a mains LED driver that can be phase dimmed. It works one rectified half-cycle at a time. It takes a phase count that runs from 0 up to the top of each half-cycle. It also takes strobes for zero-crossing, for the firing edge of a leading-edge dimmer and for the cut-off edge of a trailing-edge dimmer. Other logic detects these events. The dimmer mode picks which parts of the half-cycle are chopped with full-width pulses, which are chopped with narrow "light" pulses, and which keep the switch solidly on. Keeping the switch on loads the dimmer, so that the TRIAC latches and the dimmer resets cleanly.

The pulse engine runs all the time. Each switching period has its own length, set by a pseudo-random offset around the nominal period, which spreads the EMI. The pulse width climbs one step per period while chopping is allowed. It falls one step per period once chopping stops, which gives a soft start and a soft stop. A hold-on window always takes priority and drives the gate high.

Top module: `csq_gate_seq`

## Requirements
- R1: While reset is asserted and right after it, the gate is low. The ramp level is 0, the first period is the nominal 32 cycles and the LFSR holds its seed 16'hACE1.
- R2: Mode codes: 0 lead, 1 lead-startup, 2 lead-zero-cross, 3 trail, 4 trail-startup, 5 trail-full. The lead modes (0, 1, 2) chop at full width while phase < 128, chop light while 128 <= phase < 228, and do not chop while held. Trail modes 3 and 4 chop at full width whenever not held. Mode 5 always chops at full width. Codes 6 and 7 neither chop nor hold.
- R3: Each period gates high for its first `width` cycles. `width` = base*level/8. The base is 16 for full chopping and 4 (variant 0) or 8 (variant 1) for light chopping. The base kind is latched at the period start while chopping is allowed, and is kept otherwise.
- R4: While the latched kind is light and `vin_hi` is 1, the pulse part of the gate is low from that same cycle.
- R5: At each period start the ramp level (0..8) rises by one if chopping is allowed in that cycle, and otherwise falls by one.
- R6: The next period length is 32 + (L mod 9) - 4, where L is the current LFSR value. The LFSR then shifts left with feedback bit L[15]^L[13]^L[12]^L[10].
- R7: In modes 0 and 1 the hold sets once phase >= 245. It clears 40 cycles after the cycle of `le_stb`.
- R8: In modes 2, 3 and 4 the hold clears 24 cycles after the cycle of `zc_stb`. In mode 2 it sets once phase >= 245.
- R9: In modes 3 and 4 the hold sets once phase >= T - overlap. T is the phase captured at the last `te_stb` (reset value 255). The overlap is 10 (variant 0) or 12 (variant 1) phase steps.
- R10: The gate is high whenever the hold is set, whatever the pulse engine or `vin_hi` show.
- R11: In mode 5 the hold is never set, so no gate high run is longer than 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Dimmer mode code (R2) |
| phase | input | 8 | Half-cycle phase count, 0 at zero-crossing |
| zc_stb | input | 1 | One-cycle zero-crossing strobe |
| le_stb | input | 1 | One-cycle leading-edge (firing) strobe |
| te_stb | input | 1 | One-cycle trailing-edge (cut-off) strobe |
| vin_hi | input | 1 | Input voltage above the light-chop threshold |
| variant | input | 1 | 0: quarter-width light pulses and short overlap; 1: half-width and long overlap |
| gate | output | 1 | Chopper switch gate drive |

## Verification
Two of the block's functions can fall in the same cycle. The hold-on window can start while a pulse is partway through its ramp. Light-pulse muting can fall inside a period that is already high. The bench provokes both. It raises `vin_hi` across the boundary between full and light chopping, and it places the hold start at varying distances from period starts by changing the trailing-edge phase and the variant. A behavioural model decides each cycle which rule governs the gate (hold first, then muting, then the ramped pulse) and compares the result with the gate on every clock. Directed checks confirm the hold spans around the strobes.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [2:0] {
    MD_LEAD        = 3'd0,
    MD_LEAD_START  = 3'd1,
    MD_LEAD_ZC     = 3'd2,
    MD_TRAIL       = 3'd3,
    MD_TRAIL_START = 3'd4,
    MD_TRAIL_FULL  = 3'd5
  } dim_mode_e;

  function automatic logic [15:0] lfsr_step(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  // period = nominal + (L mod (2D+1)) - D, D = nominal/8
  function automatic int dither_per(input int nom, input logic [15:0] l);
    int d;
    d = nom / 8;
    return nom + (int'(l) % (2 * d + 1)) - d;
  endfunction

  function automatic int ramp_width(input int base, input int lvl, input int lg);
    return (base * lvl) / (1 << lg);
  endfunction

endpackage

// File: rtl/csq_dither.sv
module csq_dither
  import csq_pkg::*;
#(
  parameter int NOM_PER = 32,
  parameter int PER_W   = 6,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PER_W-1:0] per_next
);
  logic [15:0] lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= SEED;
    else if (step) lfsr <= lfsr_step(lfsr);
  end

  assign per_next = PER_W'(dither_per(NOM_PER, lfsr));
endmodule

// File: rtl/csq_window.sv
module csq_window
  import csq_pkg::*;
#(
  parameter int PH_W    = 8,
  parameter int PH_90   = 128,
  parameter int PH_160  = 228,
  parameter int PH_HOLD = 245,
  parameter int HOLD_LE = 40,
  parameter int HOLD_ZC = 24,
  parameter int OVL_A   = 10,
  parameter int OVL_B   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode,
  input  logic [PH_W-1:0] phase,
  input  logic            zc_stb,
  input  logic            le_stb,
  input  logic            te_stb,
  input  logic            variant,
  output logic            hold,
  output logic            chop_win,
  output logic            light_win
);
  localparam int TMR_MAX = (HOLD_LE > HOLD_ZC) ? HOLD_LE : HOLD_ZC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [PH_W-1:0]  P90   = PH_W'(PH_90);
  localparam logic [PH_W-1:0]  P160  = PH_W'(PH_160);
  localparam logic [PH_W-1:0]  PHOLD = PH_W'(PH_HOLD);
  localparam logic [PH_W-1:0]  OA    = PH_W'(OVL_A);
  localparam logic [PH_W-1:0]  OB    = PH_W'(OVL_B);
  localparam logic [TMR_W-1:0] T_LE  = TMR_W'(HOLD_LE);
  localparam logic [TMR_W-1:0] T_ZC  = TMR_W'(HOLD_ZC);
  localparam logic [TMR_W-1:0] T_ONE = TMR_W'(1);

  logic [PH_W-1:0]  te_ref, ovl, start_ph;
  logic [TMR_W-1:0] tmr;
  logic             hold_q, lead, lead_edge, trail, edge_stb, set_ok;

  always_comb begin
    lead      = (mode == MD_LEAD) || (mode == MD_LEAD_START) || (mode == MD_LEAD_ZC);
    lead_edge = (mode == MD_LEAD) || (mode == MD_LEAD_START);
    trail     = (mode == MD_TRAIL) || (mode == MD_TRAIL_START);
    ovl       = variant ? OB : OA;
    start_ph  = trail ? ((te_ref >= ovl) ? te_ref - ovl : '0) : PHOLD;
    edge_stb  = lead_edge ? le_stb : ((lead || trail) ? zc_stb : 1'b0);
    set_ok    = !hold_q && (phase >= start_ph);
    if (lead)                       chop_win = !hold_q && (phase < P160);
    else if (trail)                 chop_win = !hold_q;
    else if (mode == MD_TRAIL_FULL) chop_win = 1'b1;
    else                            chop_win = 1'b0;
    light_win = lead && (phase >= P90);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_ref <= '1;
      tmr    <= '0;
      hold_q <= 1'b0;
    end else begin
      if (te_stb) te_ref <= phase;
      if (!(lead || trail)) begin
        hold_q <= 1'b0;
        tmr    <= '0;
      end else if (edge_stb) begin
        tmr <= lead_edge ? T_LE : T_ZC;
      end else if (tmr != '0) begin
        tmr <= tmr - T_ONE;
        if (tmr == T_ONE) hold_q <= 1'b0;
      end else if (set_ok) begin
        hold_q <= 1'b1;
      end
    end
  end

  assign hold = hold_q;
endmodule

// File: rtl/csq_pwm.sv
module csq_pwm
  import csq_pkg::*;
#(
  parameter int NOM_PER = 32,
  parameter int NORM_W  = 16,
  parameter int RAMP_LG = 3,
  parameter int PER_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chop_win,
  input  logic               light_win,
  input  logic               variant,
  input  logic               vin_hi,
  input  logic [PER_W-1:0]   per_next,
  output logic               pstart,
  output logic               pwm_on,
  output logic               light_q,
  output logic [PER_W-1:0]   per_q,
  output logic [RAMP_LG:0]   ramp_lvl
);
  localparam int LVL_W = RAMP_LG + 1;
  localparam logic [LVL_W-1:0] LMAX = LVL_W'(1 << RAMP_LG);
  localparam logic [LVL_W-1:0] L_ONE = LVL_W'(1);

  logic [PER_W-1:0] cnt, wid, wid_n;
  logic [LVL_W-1:0] lvl_n;
  logic             kind_n;
  int               base;

  always_comb begin
    pstart = (cnt == per_q - PER_W'(1));
    if (chop_win) lvl_n = (ramp_lvl == LMAX) ? ramp_lvl : ramp_lvl + L_ONE;
    else          lvl_n = (ramp_lvl == '0)   ? ramp_lvl : ramp_lvl - L_ONE;
    kind_n = chop_win ? light_win : light_q;
    base   = kind_n ? (variant ? NORM_W / 2 : NORM_W / 4) : NORM_W;
    wid_n  = PER_W'(ramp_width(base, int'(lvl_n), RAMP_LG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      per_q    <= PER_W'(NOM_PER);
      wid      <= '0;
      ramp_lvl <= '0;
      light_q  <= 1'b0;
    end else if (pstart) begin
      cnt      <= '0;
      per_q    <= per_next;
      wid      <= wid_n;
      ramp_lvl <= lvl_n;
      light_q  <= kind_n;
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end

  assign pwm_on = (cnt < wid) && !(light_q && vin_hi);
endmodule

// File: rtl/csq_gate_seq.sv
module csq_gate_seq
  import csq_pkg::*;
#(
  parameter int PH_W    = 8,
  parameter int PH_90   = 128,
  parameter int PH_160  = 228,
  parameter int PH_HOLD = 245,
  parameter int HOLD_LE = 40,
  parameter int HOLD_ZC = 24,
  parameter int OVL_A   = 10,
  parameter int OVL_B   = 12,
  parameter int NOM_PER = 32,
  parameter int NORM_W  = 16,
  parameter int RAMP_LG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode,
  input  logic [PH_W-1:0] phase,
  input  logic            zc_stb,
  input  logic            le_stb,
  input  logic            te_stb,
  input  logic            vin_hi,
  input  logic            variant,
  output logic            gate
);
  localparam int PER_W = $clog2(NOM_PER + NOM_PER / 8 + 1);

  logic             hold, chop_win, light_win, pstart, pwm_on, light_q;
  logic [PER_W-1:0] per_q, per_next;
  logic [RAMP_LG:0] ramp_lvl;

  csq_window #(
    .PH_W(PH_W), .PH_90(PH_90), .PH_160(PH_160), .PH_HOLD(PH_HOLD),
    .HOLD_LE(HOLD_LE), .HOLD_ZC(HOLD_ZC), .OVL_A(OVL_A), .OVL_B(OVL_B)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .mode(mode), .phase(phase),
    .zc_stb(zc_stb), .le_stb(le_stb), .te_stb(te_stb), .variant(variant),
    .hold(hold), .chop_win(chop_win), .light_win(light_win)
  );

  csq_dither #(.NOM_PER(NOM_PER), .PER_W(PER_W)) u_dith (
    .clk(clk), .rst_n(rst_n), .step(pstart), .per_next(per_next)
  );

  csq_pwm #(
    .NOM_PER(NOM_PER), .NORM_W(NORM_W), .RAMP_LG(RAMP_LG), .PER_W(PER_W)
  ) u_pwm (
    .clk(clk), .rst_n(rst_n), .chop_win(chop_win), .light_win(light_win),
    .variant(variant), .vin_hi(vin_hi), .per_next(per_next),
    .pstart(pstart), .pwm_on(pwm_on), .light_q(light_q),
    .per_q(per_q), .ramp_lvl(ramp_lvl)
  );

  assign gate = hold | pwm_on;
endmodule

// File: rtl/csq_gate_seq_chk.sv
module csq_gate_seq_chk #(
  parameter int NOM_PER = 32,
  parameter int RAMP_LG = 3,
  parameter int PER_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             vin_hi,
  input logic             gate,
  input logic             hold,
  input logic             light_q,
  input logic             pstart,
  input logic [PER_W-1:0] per_q,
  input logic [RAMP_LG:0] ramp_lvl
);
  localparam logic [PER_W-1:0]   P_LO = PER_W'(NOM_PER - NOM_PER / 8);
  localparam logic [PER_W-1:0]   P_HI = PER_W'(NOM_PER + NOM_PER / 8);
  localparam logic [RAMP_LG:0]   LMAX = (RAMP_LG + 1)'(1 << RAMP_LG);

  AST_HOLD_FORCES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> gate); // R10
  AST_LIGHT_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (light_q && vin_hi && !hold) |-> !gate); // R4
  AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pstart |=> (per_q >= P_LO && per_q <= P_HI)); // R6
  AST_RAMP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !pstart |=> $stable(ramp_lvl)); // R5
  AST_RAMP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_lvl <= LMAX); // R5
  AST_FULL_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5) |=> !hold); // R11
  AST_SPARE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd6 || mode == 3'd7) |=> !hold); // R2
endmodule

bind csq_gate_seq csq_gate_seq_chk #(
  .NOM_PER(NOM_PER), .RAMP_LG(RAMP_LG), .PER_W(PER_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .vin_hi(vin_hi), .gate(gate),
  .hold(hold), .light_q(light_q), .pstart(pstart), .per_q(per_q),
  .ramp_lvl(ramp_lvl)
);

// File: tb/tb_csq_gate_seq.sv
module tb_csq_gate_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] phase = 8'd0;
  logic       zc_stb = 1'b0, le_stb = 1'b0, te_stb = 1'b0;
  logic       vin_hi = 1'b0, variant = 1'b0;
  logic       gate;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int cur_half = 0, cur_ph = 0, cur_s = 0, cur_te = 0;

  // reference model state
  int m_cnt, m_per, m_w, m_lvl, m_light, m_lfsr, m_h, m_tmr, m_te;
  int run_len = 0, last_rise = -1, cyc = 0;
  bit prev_gate = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  csq_gate_seq dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .phase(phase), .zc_stb(zc_stb),
    .le_stb(le_stb), .te_stb(te_stb), .vin_hi(vin_hi), .variant(variant),
    .gate(gate)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int next_lfsr(input int l);
    int fb;
    fb = ((l >> 15) ^ (l >> 13) ^ (l >> 12) ^ (l >> 10)) & 1;
    return ((l << 1) | fb) & 16'hFFFF;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_per = 32; m_w = 0; m_lvl = 0; m_light = 0;
    m_lfsr = 16'hACE1; m_h = 0; m_tmr = 0; m_te = 255;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      model_reset();
      chk(gate == 1'b0, "R1", int'(gate), 0);
    end else begin
      bit exp, lead, trail, win, lt, stb;
      int nl, base, st, ov;
      string tag;
      exp = (m_h != 0) || (m_cnt < m_w && !(m_light != 0 && vin_hi));
      tag = (m_h != 0) ? "R10" : ((m_light != 0 && vin_hi) ? "R4" : "R3,R5");
      chk(gate == exp, tag, int'(gate), int'(exp));

      // directed checks at hold spans and idle modes
      if (cur_half >= 1 && cur_s == 0) begin
        if ((mode == 3'd0 || mode == 3'd1) && cur_ph == 10)
          chk(gate == 1'b1, "R7", int'(gate), 1);
        if (mode == 3'd2 && cur_ph == 5)
          chk(gate == 1'b1, "R8", int'(gate), 1);
        if ((mode == 3'd3 || mode == 3'd4) && cur_ph == cur_te - 3)
          chk(gate == 1'b1, "R9", int'(gate), 1);
        if (mode == 3'd6 && cur_ph == 100)
          chk(gate == 1'b0, "R2", int'(gate), 0);
      end
      if (mode == 3'd5 && cur_half >= 1) begin
        if (gate) run_len++;
        if (!gate && prev_gate) chk(run_len <= 16, "R11", run_len, 16);
        if (gate && !prev_gate) begin
          if (last_rise >= 0)
            chk((cyc - last_rise) >= 28 && (cyc - last_rise) <= 36, "R6",
                cyc - last_rise, 32);
          last_rise = cyc;
        end
        if (!gate) run_len = 0;
      end else begin
        run_len = 0; last_rise = -1;
      end
      prev_gate = gate;

      // advance model to the state after the coming clock edge
      lead  = (mode <= 3'd2);
      trail = (mode == 3'd3 || mode == 3'd4);
      win   = lead ? (m_h == 0 && phase < 8'd228) : (trail ? (m_h == 0) : (mode == 3'd5));
      lt    = lead && phase >= 8'd128;
      if (m_cnt == m_per - 1) begin
        nl = win ? ((m_lvl < 8) ? m_lvl + 1 : 8) : ((m_lvl > 0) ? m_lvl - 1 : 0);
        if (win) m_light = lt ? 1 : 0;
        base  = (m_light != 0) ? (variant ? 8 : 4) : 16;
        m_w   = base * nl / 8;
        m_lvl = nl;
        m_per = 32 + (m_lfsr % 9) - 4;
        m_lfsr = next_lfsr(m_lfsr);
        m_cnt = 0;
      end else m_cnt++;
      ov  = variant ? 12 : 10;
      st  = trail ? ((m_te >= ov) ? m_te - ov : 0) : 245;
      stb = (mode <= 3'd1) ? le_stb : ((lead || trail) ? zc_stb : 1'b0);
      if (!(lead || trail)) begin m_h = 0; m_tmr = 0; end
      else if (stb) m_tmr = (mode <= 3'd1) ? 40 : 24;
      else if (m_tmr != 0) begin
        if (m_tmr == 1) m_h = 0;
        m_tmr--;
      end else if (m_h == 0 && int'(phase) >= st) m_h = 1;
      if (te_stb) m_te = int'(phase);
    end
  end

  // one segment: several half-cycles, two clocks per phase step
  task automatic run_seg(input int md, input bit vr, input bit vpat,
                         input int le_at, input int te_at, input int halves);
    mode = 3'(md); variant = vr; cur_te = te_at;
    for (int h = 0; h < halves; h++) begin
      cur_half = h;
      for (int p = 0; p < 256; p++) begin
        for (int s = 0; s < 2; s++) begin
          @(posedge clk); #1;
          cur_ph = p; cur_s = s;
          phase  = 8'(p);
          zc_stb = (p == 0 && s == 0);
          le_stb = (le_at >= 0 && p == le_at && s == 0);
          te_stb = (te_at >= 0 && p == te_at && s == 0);
          vin_hi = vpat && p >= 120 && p < 175;
        end
      end
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(gate == 1'b0, "R1", int'(gate), 0);
    run_seg(0, 1'b0, 1'b0, 60, -1, 3);   // R7 lead, no muting
    run_seg(0, 1'b1, 1'b1, 70, -1, 3);   // R3 R4 light at half width with muting
    run_seg(1, 1'b0, 1'b1, 40, -1, 3);   // R2 startup lead
    run_seg(2, 1'b1, 1'b0, -1, -1, 3);   // R8 zero-cross hold
    run_seg(3, 1'b0, 1'b0, -1, 200, 3);  // R9 overlap variant 0
    run_seg(4, 1'b1, 1'b1, -1, 180, 3);  // R9 overlap variant 1
    run_seg(5, 1'b0, 1'b1, -1, 190, 3);  // R6 R11 full chopping
    run_seg(6, 1'b0, 1'b0, -1, -1, 2);   // R2 spare code idles
    run_seg(0, 1'b0, 1'b1, 90, -1, 2);   // R5 ramp after idle
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule